// File: doc/BRIEF.md
# Synthesizer Divider Setting Register Bank

This block stores the divider programming of an integer-N frequency synthesizer: a 9-bit main divide value, a 6-bit reference divide value, a 4-bit swallow value and a prescaler-enable flag. It can take these settings in three ways: as a 20-bit word shifted in one bit at a time, as three byte-wide writes that each fill part of the setting, or straight from a set of direct pins with no storage.

Two complete copies of the setting are kept, a primary set and a secondary set. Byte-wide writes fill the primary set and serial loads fill the secondary set. A level select input picks which set drives the outputs, so a new setting can be prepared in the idle set and switched in later without any reload. All write strobes and the serial clock are asynchronous to the system clock. Each one passes through a two-flop synchronizer and a rising-edge detector before it acts. The outputs are registered.

Top module: `pll_divider_regbank`

## Requirements
- R1: While `rst` is high at a clock edge, the primary set, the secondary set, the serial shifter and all outputs are cleared to zero.
- R2: Loads are decoded only when `enh` is 1. With `bmode`=0 and `smode`=0 the block is in byte mode. With `bmode`=0 and `smode`=1 it is in serial mode. With `bmode`=1 it is in direct mode, whatever `smode` is. With `enh`=0 no strobe changes either stored set.
- R3: In serial mode, each detected rising edge of `sclk` while `aux_wr` is 0 shifts `sdata` into bit 0 of a 20-bit shifter, so the first bit sent ends up in bit 19. While `aux_wr` is 1 the shifter holds its value.
- R4: The serial word, from bit 19 (first sent) down to bit 0, is reference bits 5 and 4, main bits 8 and 7, prescaler enable, main bits 6 to 0, reference bits 3 to 0, swallow bits 3 to 0.
- R5: In serial mode, a detected rising edge of `ser_wr` copies the decoded shifter word into the secondary set. If a shift happens in the same cycle, the copied word already includes the bit shifted in that cycle.
- R6: In byte mode, a detected rising edge of `wr_hi` loads `pdata[3]`, `pdata[2]`, `pdata[1]`, `pdata[0]` into primary reference bits 5 and 4 and main bits 8 and 7. `pdata[7:4]` is ignored.
- R7: In byte mode, a detected rising edge of `wr_mid` loads `pdata[7]` into the primary prescaler enable and `pdata[6:0]` into primary main bits 6 to 0.
- R8: In byte mode, a detected rising edge of `wr_lo` loads `pdata[7:4]` into primary reference bits 3 to 0 and `pdata[3:0]` into the primary swallow value.
- R9: Outside direct mode, the outputs show the primary set one clock after `sel_primary` is sampled high, and the secondary set one clock after it is sampled low. Loading the set that is not selected changes no output.
- R10: In direct mode, the outputs one clock later are `dir_pre_en`, `{2'b00, dir_m}`, `{2'b00, dir_r}` and `dir_a`, whatever `sel_primary` is. Neither stored set is changed, and the stored values reappear when the block leaves direct mode.
- R11: A strobe or `sclk` level that is first sampled high at clock edge k, after being low for the previous samples, changes the stored set at edge k+2. The change reaches the outputs after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enh | input | 1 | Mode decode enable; 0 blocks all loads |
| bmode | input | 1 | 1 selects direct mode |
| smode | input | 1 | With bmode=0: 1 serial, 0 byte mode |
| sclk | input | 1 | Serial bit clock (asynchronous) |
| sdata | input | 1 | Serial data bit |
| aux_wr | input | 1 | Shift gate; shifting is allowed only while low |
| ser_wr | input | 1 | Serial capture strobe into the secondary set |
| wr_hi | input | 1 | Byte strobe for the upper reference and main bits |
| wr_mid | input | 1 | Byte strobe for prescaler enable and lower main bits |
| wr_lo | input | 1 | Byte strobe for the lower reference and swallow bits |
| pdata | input | 8 | Byte write data |
| sel_primary | input | 1 | 1 selects the primary set, 0 the secondary set |
| dir_pre_en | input | 1 | Direct prescaler enable |
| dir_m | input | 7 | Direct main divide bits 6..0 |
| dir_r | input | 4 | Direct reference divide bits 3..0 |
| dir_a | input | 4 | Direct swallow value |
| m_div | output | 9 | Selected main divide value |
| r_div | output | 6 | Selected reference divide value |
| a_div | output | 4 | Selected swallow value |
| pre_en | output | 1 | Selected prescaler enable |

## Verification
A serial shift and a capture into the secondary set can fall in the same cycle. The bench provokes this by raising `sclk` and `ser_wr` together on the last bit of a word. The result passes only if the secondary set holds the full 20-bit word with the final bit included. A select change can also coincide with a load of the newly selected set. Both cases are judged by a behavioural model that applies the same order on every clock: output first from the old state, then the shift, then the capture. The bench also checks the decoded fields at the ports.

// File: rtl/pll_regbank_pkg.sv
package pll_regbank_pkg;

  localparam int M_W    = 9;
  localparam int R_W    = 6;
  localparam int A_W    = 4;
  localparam int WORD_W = 1 + M_W + R_W + A_W;
  localparam int BYTE_W = 8;
  localparam int DM_W   = M_W - 2;
  localparam int DR_W   = R_W - 2;

  typedef struct packed {
    logic           pre_en;
    logic [M_W-1:0] m;
    logic [R_W-1:0] r;
    logic [A_W-1:0] a;
  } div_set_t;

  typedef enum logic [1:0] {
    LD_OFF = 2'd0,
    LD_BYTE = 2'd1,
    LD_SER = 2'd2,
    LD_DIR = 2'd3
  } load_mode_e;

  localparam int STB_SCLK = 0;
  localparam int STB_SWR  = 1;
  localparam int STB_HI   = 2;
  localparam int STB_MID  = 3;
  localparam int STB_LO   = 4;
  localparam int STB_N    = 5;

  function automatic div_set_t unpack_word(input logic [WORD_W-1:0] w);
    div_set_t s;
    s.r[R_W-1]     = w[WORD_W-1];
    s.r[R_W-2]     = w[WORD_W-2];
    s.m[M_W-1]     = w[WORD_W-3];
    s.m[M_W-2]     = w[WORD_W-4];
    s.pre_en       = w[WORD_W-5];
    s.m[DM_W-1:0]  = w[WORD_W-6 -: DM_W];
    s.r[DR_W-1:0]  = w[A_W +: DR_W];
    s.a            = w[A_W-1:0];
    return s;
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int N      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] rise
);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_line
      logic [STAGES:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-1:0], raw[g]};
      end
      assign rise[g] = pipe[STAGES-1] & ~pipe[STAGES];
    end
  endgenerate

endmodule

// File: rtl/serial_shifter.sv
module serial_shifter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word_q,
  output logic [W-1:0] word_nxt
);

  always_comb begin
    word_nxt = word_q;
    if (shift_en) word_nxt = {word_q[W-2:0], bit_in};
  end

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= word_nxt;
  end

endmodule

// File: rtl/div_reg_bank.sv
module div_reg_bank
  import pll_regbank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  load_mode_e           mode,
  input  logic                 hi_p,
  input  logic                 mid_p,
  input  logic                 lo_p,
  input  logic [BYTE_W-1:0]    pdata,
  input  logic                 cap_p,
  input  logic [WORD_W-1:0]    cap_word,
  output div_set_t             prim_q,
  output div_set_t             sec_q
);

  div_set_t prim_d, sec_d;

  always_comb begin
    prim_d = prim_q;
    if (mode == LD_BYTE) begin
      if (hi_p) begin
        prim_d.r[R_W-1:R_W-2] = pdata[3:2];
        prim_d.m[M_W-1:M_W-2] = pdata[1:0];
      end
      if (mid_p) begin
        prim_d.pre_en        = pdata[BYTE_W-1];
        prim_d.m[DM_W-1:0]   = pdata[DM_W-1:0];
      end
      if (lo_p) begin
        prim_d.r[DR_W-1:0]   = pdata[BYTE_W-1 -: DR_W];
        prim_d.a             = pdata[A_W-1:0];
      end
    end
  end

  always_comb begin
    sec_d = sec_q;
    if (mode == LD_SER && cap_p) sec_d = unpack_word(cap_word);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prim_q <= '0;
      sec_q  <= '0;
    end else begin
      prim_q <= prim_d;
      sec_q  <= sec_d;
    end
  end

endmodule

// File: rtl/div_out_sel.sv
module div_out_sel
  import pll_regbank_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  load_mode_e      mode,
  input  logic            sel_primary,
  input  div_set_t        prim,
  input  div_set_t        sec,
  input  logic            dir_pre_en,
  input  logic [DM_W-1:0] dir_m,
  input  logic [DR_W-1:0] dir_r,
  input  logic [A_W-1:0]  dir_a,
  output div_set_t        out_q
);

  div_set_t src;

  always_comb begin
    if (mode == LD_DIR) begin
      src.pre_en = dir_pre_en;
      src.m      = {2'b00, dir_m};
      src.r      = {2'b00, dir_r};
      src.a      = dir_a;
    end else if (sel_primary) begin
      src = prim;
    end else begin
      src = sec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= src;
  end

endmodule

// File: rtl/pll_divider_regbank.sv
module pll_divider_regbank
  import pll_regbank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enh,
  input  logic            bmode,
  input  logic            smode,
  input  logic            sclk,
  input  logic            sdata,
  input  logic            aux_wr,
  input  logic            ser_wr,
  input  logic            wr_hi,
  input  logic            wr_mid,
  input  logic            wr_lo,
  input  logic [7:0]      pdata,
  input  logic            sel_primary,
  input  logic            dir_pre_en,
  input  logic [6:0]      dir_m,
  input  logic [3:0]      dir_r,
  input  logic [3:0]      dir_a,
  output logic [8:0]      m_div,
  output logic [5:0]      r_div,
  output logic [3:0]      a_div,
  output logic            pre_en
);

  load_mode_e        mode;
  logic [STB_N-1:0]  raw_stb, rise_stb;
  logic [WORD_W-1:0] shift_q, shift_nxt;
  logic              shift_en;
  div_set_t          prim_q, sec_q, out_q;

  always_comb begin
    if (!enh)       mode = LD_OFF;
    else if (bmode) mode = LD_DIR;
    else if (smode) mode = LD_SER;
    else            mode = LD_BYTE;
  end

  always_comb begin
    raw_stb           = '0;
    raw_stb[STB_SCLK] = sclk;
    raw_stb[STB_SWR]  = ser_wr;
    raw_stb[STB_HI]   = wr_hi;
    raw_stb[STB_MID]  = wr_mid;
    raw_stb[STB_LO]   = wr_lo;
  end

  strobe_sync #(.N(STB_N), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .raw  (raw_stb),
    .rise (rise_stb)
  );

  assign shift_en = (mode == LD_SER) && !aux_wr && rise_stb[STB_SCLK];

  serial_shifter #(.W(WORD_W)) i_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .bit_in   (sdata),
    .word_q   (shift_q),
    .word_nxt (shift_nxt)
  );

  div_reg_bank i_bank (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .hi_p     (rise_stb[STB_HI]),
    .mid_p    (rise_stb[STB_MID]),
    .lo_p     (rise_stb[STB_LO]),
    .pdata    (pdata),
    .cap_p    (rise_stb[STB_SWR]),
    .cap_word (shift_nxt),
    .prim_q   (prim_q),
    .sec_q    (sec_q)
  );

  div_out_sel i_out (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode),
    .sel_primary (sel_primary),
    .prim        (prim_q),
    .sec         (sec_q),
    .dir_pre_en  (dir_pre_en),
    .dir_m       (dir_m),
    .dir_r       (dir_r),
    .dir_a       (dir_a),
    .out_q       (out_q)
  );

  assign m_div  = out_q.m;
  assign r_div  = out_q.r;
  assign a_div  = out_q.a;
  assign pre_en = out_q.pre_en;

endmodule

// File: rtl/pll_divider_regbank_chk.sv
module pll_divider_regbank_chk
  import pll_regbank_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              enh,
  input logic              bmode,
  input logic              smode,
  input logic              aux_wr,
  input logic              sel_primary,
  input logic [6:0]        dir_m,
  input logic [3:0]        dir_r,
  input logic [3:0]        dir_a,
  input logic              dir_pre_en,
  input logic [8:0]        m_div,
  input logic [5:0]        r_div,
  input logic [3:0]        a_div,
  input logic              pre_en,
  input div_set_t          prim_q,
  input div_set_t          sec_q,
  input logic [WORD_W-1:0] shift_q
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (m_div == '0 && r_div == '0 && a_div == '0 && !pre_en)); // R1

  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !enh |=> ($stable(prim_q) && $stable(sec_q))); // R2

  AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (rst)
    aux_wr |=> $stable(shift_q)); // R3

  AST_BYTE_SPARES_SEC: assert property (@(posedge clk) disable iff (rst)
    (enh && !bmode && !smode) |=> $stable(sec_q)); // R6

  AST_SER_SPARES_PRIM: assert property (@(posedge clk) disable iff (rst)
    (enh && !bmode && smode) |=> $stable(prim_q)); // R5

  AST_SHOWS_PRIMARY: assert property (@(posedge clk) disable iff (rst)
    (!(enh && bmode) && sel_primary) |=>
      (m_div == $past(prim_q.m) && r_div == $past(prim_q.r) &&
       a_div == $past(prim_q.a) && pre_en == $past(prim_q.pre_en))); // R9

  AST_SHOWS_SECONDARY: assert property (@(posedge clk) disable iff (rst)
    (!(enh && bmode) && !sel_primary) |=>
      (m_div == $past(sec_q.m) && r_div == $past(sec_q.r) &&
       a_div == $past(sec_q.a) && pre_en == $past(sec_q.pre_en))); // R9

  AST_DIRECT_PINS: assert property (@(posedge clk) disable iff (rst)
    (enh && bmode) |=>
      (m_div == {2'b00, $past(dir_m)} && r_div == {2'b00, $past(dir_r)} &&
       a_div == $past(dir_a) && pre_en == $past(dir_pre_en))); // R10

endmodule

bind pll_divider_regbank pll_divider_regbank_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .enh         (enh),
  .bmode       (bmode),
  .smode       (smode),
  .aux_wr      (aux_wr),
  .sel_primary (sel_primary),
  .dir_m       (dir_m),
  .dir_r       (dir_r),
  .dir_a       (dir_a),
  .dir_pre_en  (dir_pre_en),
  .m_div       (m_div),
  .r_div       (r_div),
  .a_div       (a_div),
  .pre_en      (pre_en),
  .prim_q      (prim_q),
  .sec_q       (sec_q),
  .shift_q     (shift_q)
);

// File: tb/test_pll_divider_regbank.sv
`timescale 1ns/1ps
module test_pll_divider_regbank;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enh = 1'b0, bmode = 1'b0, smode = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, aux_wr = 1'b0, ser_wr = 1'b0;
  logic wr_hi = 1'b0, wr_mid = 1'b0, wr_lo = 1'b0;
  logic [7:0] pdata = 8'h00;
  logic sel_primary = 1'b1;
  logic dir_pre_en = 1'b0;
  logic [6:0] dir_m = '0;
  logic [3:0] dir_r = '0, dir_a = '0;
  logic [8:0] m_div;
  logic [5:0] r_div;
  logic [3:0] a_div;
  logic pre_en;

  int checks = 0, errors = 0;
  bit done = 0, model_ok = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  pll_divider_regbank i_pll_divider_regbank (
    .clk(clk), .rst(rst), .enh(enh), .bmode(bmode), .smode(smode),
    .sclk(sclk), .sdata(sdata), .aux_wr(aux_wr), .ser_wr(ser_wr),
    .wr_hi(wr_hi), .wr_mid(wr_mid), .wr_lo(wr_lo), .pdata(pdata),
    .sel_primary(sel_primary), .dir_pre_en(dir_pre_en), .dir_m(dir_m),
    .dir_r(dir_r), .dir_a(dir_a), .m_div(m_div), .r_div(r_div),
    .a_div(a_div), .pre_en(pre_en)
  );

  // Behavioural reference model
  bit [8:0] pm, sm, em;
  bit [5:0] pr, sr_, er;
  bit [3:0] pa, sa, ea;
  bit       pp, sp, ep;
  bit [19:0] shw;
  bit [2:0] h_sclk, h_swr, h_hi, h_mid, h_lo;

  always @(posedge clk) begin
    bit r_sclk, r_swr, r_hi, r_mid, r_lo, is_ser, is_byte;
    if (rst) begin
      pm = 0; sm = 0; em = 0; pr = 0; sr_ = 0; er = 0;
      pa = 0; sa = 0; ea = 0; pp = 0; sp = 0; ep = 0; shw = 0;
      h_sclk = 0; h_swr = 0; h_hi = 0; h_mid = 0; h_lo = 0;
    end else begin
      if (enh && bmode) begin
        em = {2'b00, dir_m}; er = {2'b00, dir_r}; ea = dir_a; ep = dir_pre_en;
      end else if (sel_primary) begin
        em = pm; er = pr; ea = pa; ep = pp;
      end else begin
        em = sm; er = sr_; ea = sa; ep = sp;
      end
      r_sclk = h_sclk[1] && !h_sclk[2];
      r_swr  = h_swr[1]  && !h_swr[2];
      r_hi   = h_hi[1]   && !h_hi[2];
      r_mid  = h_mid[1]  && !h_mid[2];
      r_lo   = h_lo[1]   && !h_lo[2];
      h_sclk = {h_sclk[1:0], sclk};
      h_swr  = {h_swr[1:0], ser_wr};
      h_hi   = {h_hi[1:0], wr_hi};
      h_mid  = {h_mid[1:0], wr_mid};
      h_lo   = {h_lo[1:0], wr_lo};
      is_ser  = enh && !bmode && smode;
      is_byte = enh && !bmode && !smode;
      if (is_ser && r_sclk && !aux_wr) shw = {shw[18:0], sdata};
      if (is_ser && r_swr) begin
        sr_ = {shw[19], shw[18], shw[7:4]};
        sm  = {shw[17], shw[16], shw[14:8]};
        sp  = shw[15];
        sa  = shw[3:0];
      end
      if (is_byte && r_hi)  begin pr[5:4] = pdata[3:2]; pm[8:7] = pdata[1:0]; end
      if (is_byte && r_mid) begin pp = pdata[7]; pm[6:0] = pdata[6:0]; end
      if (is_byte && r_lo)  begin pr[3:0] = pdata[7:4]; pa = pdata[3:0]; end
    end
    model_ok = 1;
  end

  always @(negedge clk) begin
    if (model_ok && !done) begin
      checks++;
      if (m_div !== em || r_div !== er || a_div !== ea || pre_en !== ep) begin
        errors++;
        $display("FAIL %s model: got m=%h r=%h a=%h p=%b exp m=%h r=%h a=%h p=%b",
                 cur_req, m_div, r_div, a_div, pre_en, em, er, ea, ep);
      end
    end
  end

  task automatic chk(input string req, input logic [8:0] m, input logic [5:0] r,
                     input logic [3:0] a, input logic p);
    checks++;
    if (m_div !== m || r_div !== r || a_div !== a || pre_en !== p) begin
      errors++;
      $display("FAIL %s: got m=%h r=%h a=%h p=%b exp m=%h r=%h a=%h p=%b",
               req, m_div, r_div, a_div, pre_en, m, r, a, p);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_hi(input logic [7:0] d);
    pdata = d; wr_hi = 1; wait_n(4); wr_hi = 0; wait_n(4);
  endtask
  task automatic pulse_mid(input logic [7:0] d);
    pdata = d; wr_mid = 1; wait_n(4); wr_mid = 0; wait_n(4);
  endtask
  task automatic pulse_lo(input logic [7:0] d);
    pdata = d; wr_lo = 1; wait_n(4); wr_lo = 0; wait_n(4);
  endtask

  task automatic send_bit(input logic b);
    sdata = b; sclk = 1; wait_n(3); sclk = 0; wait_n(3);
  endtask

  task automatic capture();
    ser_wr = 1; wait_n(4); ser_wr = 0; wait_n(4);
  endtask

  // R4 word layout, first sent at bit 19
  function automatic logic [19:0] mk_word(input logic [8:0] m, input logic [5:0] r,
                                          input logic [3:0] a, input logic p);
    return {r[5], r[4], m[8], m[7], p, m[6:0], r[3:0], a};
  endfunction

  task automatic send_word(input logic [19:0] w, input bit last_with_cap);
    for (int i = 19; i >= 1; i--) send_bit(w[i]);
    if (last_with_cap) begin
      sdata = w[0]; sclk = 1; ser_wr = 1; wait_n(4);
      sclk = 0; ser_wr = 0; wait_n(4);
    end else begin
      send_bit(w[0]);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(4);
    cur_req = "R1";
    chk("R1 reset", 9'h0, 6'h0, 4'h0, 1'b0);
    rst = 0;
    wait_n(2);

    // Byte mode loads into primary, shown with select high
    cur_req = "R6";
    enh = 1; bmode = 0; smode = 0; sel_primary = 1;
    pulse_hi(8'hF9);
    cur_req = "R7";
    pulse_mid(8'hA5);
    cur_req = "R8";
    pulse_lo(8'h3C);
    wait_n(2);
    chk("R6 R7 R8 byte fields", 9'h0A5, 6'h23, 4'hC, 1'b1);

    // Serial load into secondary while primary selected
    cur_req = "R3";
    smode = 1; aux_wr = 0;
    send_word(mk_word(9'b110011001, 6'b011010, 4'b0110, 1'b0), 0);
    capture();
    chk("R9 unselected load hidden", 9'h0A5, 6'h23, 4'hC, 1'b1);
    sel_primary = 0;
    @(negedge clk);
    chk("R4 R9 secondary after one clock", 9'b110011001, 6'b011010, 4'b0110, 1'b0);
    sel_primary = 1;
    @(negedge clk);
    chk("R9 back to primary", 9'h0A5, 6'h23, 4'hC, 1'b1);
    sel_primary = 0;

    // Shift gated by aux_wr
    cur_req = "R3";
    aux_wr = 1;
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    aux_wr = 0;
    capture();
    chk("R3 aux_wr high blocks shift", 9'b110011001, 6'b011010, 4'b0110, 1'b0);

    // enh low blocks byte writes
    cur_req = "R2";
    enh = 0; smode = 0; sel_primary = 1;
    pulse_mid(8'h00);
    pulse_lo(8'hFF);
    wait_n(2);
    chk("R2 enh low no load", 9'h0A5, 6'h23, 4'hC, 1'b1);

    // Direct mode, smode both values, select ignored
    cur_req = "R10";
    enh = 1; bmode = 1; smode = 0;
    dir_pre_en = 1; dir_m = 7'h5A; dir_r = 4'h9; dir_a = 4'h3;
    wait_n(2);
    chk("R10 direct smode0", 9'h05A, 6'h09, 4'h3, 1'b1);
    smode = 1; sel_primary = 0;
    wait_n(2);
    chk("R2 R10 direct smode1 sel low", 9'h05A, 6'h09, 4'h3, 1'b1);
    pulse_lo(8'h77);
    bmode = 0; smode = 0; sel_primary = 1;
    wait_n(2);
    chk("R10 stored set returns", 9'h0A5, 6'h23, 4'hC, 1'b1);

    // Shift and capture in the same cycle
    cur_req = "R5";
    smode = 1; sel_primary = 0;
    send_word(mk_word(9'b001110010, 6'b101101, 4'b1001, 1'b1), 1);
    chk("R5 capture includes same-cycle bit", 9'b001110010, 6'b101101, 4'b1001, 1'b1);

    // Latency of a strobe to the outputs
    cur_req = "R11";
    smode = 0; sel_primary = 1;
    wait_n(2);
    pdata = 8'h5E; wr_lo = 1;
    wait_n(3);
    chk("R11 unchanged after edge k+2", 9'h0A5, 6'h23, 4'hC, 1'b1);
    @(negedge clk);
    chk("R11 changed after edge k+3", 9'h0A5, 6'h25, 4'hE, 1'b1);
    wr_lo = 0;
    wait_n(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule